// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits between a CPU-side register interface and a handful of on-chip configuration targets. Software first writes a 32-bit configuration address into an address port. When the enable bit of that address is set, the block splits out the bus, device, function, register and type fields, compares bus and device against a parameter table of target slots, and runs a one-cycle configuration read to the matching slot. The returned dword lands in a four-byte data latch.

The CPU then reads or writes the latch through a four-byte data window. Bytes are kept in little-endian lane order, so a halfword or word access sees the lanes combined with the lowest lane as the least significant byte. Every legal write to the window merges the new byte or halfword into the latch and issues a configuration write of the whole dword, with byte enables marking the lanes that changed. Two sticky flags report accesses of an illegal size and accesses with a nonzero function or type field.

Top module: `cfg_port_decoder`

## Requirements
- R1: The address port answers at window offsets 0x000000 and 0xCF8. A word write (size code 2) stores the value and any read returns it. A byte or halfword write there leaves the stored value unchanged and sets err_size.
- R2: An address write with bit 31 set starts a configuration read in the following cycle: one cfg_stb bit high, cfg_we low, cfg_be 4'hF and cfg_reg equal to address bits 7:2. Bus is taken from bits 23:16 and device from bits 15:11.
- R3: At the end of the read strobe cycle the latch takes the selected slot's cfg_rdata. If no slot matches, no strobe is raised and the latch becomes zero.
- R4: The data window answers at 0x200000-0x200003 and at 0xCFC-0xCFF, with lane = address bits 1:0. A read returns latch lane bytes zero-extended: a word is {lane3,lane2,lane1,lane0}, the halfword at lane 0 is {lane1,lane0}, the halfword at lane 2 is {lane3,lane2}, and a byte returns its own lane.
- R5: Legal sizes are: byte at any lane, halfword at lanes 0 and 2, and word at lane 0 only (size codes 0 byte, 1 halfword, 2 word, 3 never legal). An illegal data access sets err_size, reads as zero, leaves the latch unchanged and raises no strobe.
- R6: A legal data write with the enable bit set merges the new lanes into the latch. In the next cycle it raises cfg_stb to the matching slot with cfg_we high, cfg_wdata equal to the merged dword and cfg_be marking the written lanes.
- R7: While the stored enable bit is clear, address writes raise no strobe, and data writes neither change the latch nor raise a strobe.
- R8: A configuration cycle whose function field (bits 10:8) or type field (bits 1:0) is nonzero sets err_unsup. The cycle still goes to the slot selected by bus and device.
- R9: At most one cfg_stb bit is high. When two slots hold the same bus and device, the lowest slot index is the one selected.
- R10: After reset the address register, latch, strobes and both flags are zero. err_size and err_unsup stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Offset within the port window |
| cpu_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_rdata | output | 32 | Read data, right-aligned, combinational |
| cfg_stb | output | NUM_SLOTS | One-cycle configuration strobe, one bit per slot |
| cfg_we | output | 1 | Configuration write when high, read when low |
| cfg_reg | output | 6 | Dword index of the configuration register |
| cfg_be | output | 4 | Byte enables of the configuration cycle |
| cfg_wdata | output | 32 | Dword written to the target |
| cfg_rdata | input | NUM_SLOTS*32 | Read dword returned by each slot during its strobe |
| err_size | output | 1 | Sticky: an access of illegal size was seen |
| err_unsup | output | 1 | Sticky: a cycle with nonzero function or type was issued |

## Verification
The in-RTL assertions check these properties on every cycle: at most one strobe is high, a strobe appears only while the stored enable is set, read strobes carry full byte enables, an illegal-size write leaves the latch as it was, a legal enabled write to a matched slot raises a write strobe, and the error flags stay set once raised. Lane ordering on reads, the exact merged write dword and its byte enables, zero fill for unmatched reads, the lowest-index choice among duplicate slots and the behaviour of both address mirrors all depend on concrete values. Only the bench scenarios show those, by comparing port values with results worked out from the requirements.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } size_e;

   typedef struct packed {
      logic       en;
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] fn;
      logic [5:0] reg_ix;
      logic [1:0] kind;
   } cfg_addr_t;

   // Field positions are fixed by software convention.
   function automatic cfg_addr_t split_addr(input logic [31:0] a);
      cfg_addr_t f;
      f.en     = a[31];
      f.bus    = a[23:16];
      f.dev    = a[15:11];
      f.fn     = a[10:8];
      f.reg_ix = a[7:2];
      f.kind   = a[1:0];
      return f;
   endfunction

endpackage

// File: rtl/cfgp_window_decode.sv
module cfgp_window_decode #(
   parameter int              ADDR_W      = 22,
   parameter logic [ADDR_W-1:0] ADDR_PORT_A = 'h000000,
   parameter logic [ADDR_W-1:0] ADDR_PORT_B = 'h000CF8,
   parameter logic [ADDR_W-1:0] DATA_BASE_A = 'h200000,
   parameter logic [ADDR_W-1:0] DATA_BASE_B = 'h000CFC
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_addr,
   output logic              hit_data,
   output logic [1:0]        lane
);
   localparam int HI = ADDR_W - 1;

   if (DATA_BASE_A[1:0] != 2'b00 || DATA_BASE_B[1:0] != 2'b00) begin : g_chk_align
      $error("data window bases must be dword aligned");
   end
   if (ADDR_PORT_A[1:0] != 2'b00 || ADDR_PORT_B[1:0] != 2'b00) begin : g_chk_aport
      $error("address port offsets must be dword aligned");
   end

   always_comb begin
      hit_addr = (addr == ADDR_PORT_A) || (addr == ADDR_PORT_B);
      hit_data = (addr[HI:2] == DATA_BASE_A[HI:2]) || (addr[HI:2] == DATA_BASE_B[HI:2]);
      lane     = addr[1:0];
   end

endmodule

// File: rtl/cfgp_lane_unit.sv
module cfgp_lane_unit
   import cfgp_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0] latch,
   input  logic [1:0]         lane,
   input  size_e              size,
   input  logic [31:0]        wdata,
   output logic               legal,
   output logic [LANES-1:0]   be,
   output logic [8*LANES-1:0] merged,
   output logic [31:0]        rd_val
);
   localparam int DW = 8 * LANES;

   if (LANES != 4) begin : g_chk_lanes
      $error("lane unit is built for a four-byte window");
   end

   logic [LANES-1:0] base_mask;
   logic [DW-1:0]    shifted;
   logic [DW-1:0]    rd_shift;

   always_comb begin
      unique case (size)
         SZ_BYTE: legal = 1'b1;
         SZ_HALF: legal = ~lane[0];
         SZ_WORD: legal = (lane == 2'd0);
         default: legal = 1'b0;
      endcase
      unique case (size)
         SZ_BYTE: base_mask = 4'b0001;
         SZ_HALF: base_mask = 4'b0011;
         SZ_WORD: base_mask = 4'b1111;
         default: base_mask = 4'b0000;
      endcase
      be       = legal ? (base_mask << lane) : '0;
      shifted  = wdata << {lane, 3'b000};
      rd_shift = latch >> {lane, 3'b000};
      if (!legal) begin
         rd_val = '0;
      end else begin
         unique case (size)
            SZ_BYTE: rd_val = {24'd0, rd_shift[7:0]};
            SZ_HALF: rd_val = {16'd0, rd_shift[15:0]};
            default: rd_val = rd_shift;
         endcase
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign merged[8*k +: 8] = be[k] ? shifted[8*k +: 8] : latch[8*k +: 8];
   end

endmodule

// File: rtl/cfgp_slot_match.sv
module cfgp_slot_match #(
   parameter int                   NUM_SLOTS = 4,
   parameter logic [NUM_SLOTS*8-1:0] SLOT_BUS = '0,
   parameter logic [NUM_SLOTS*5-1:0] SLOT_DEV = '0
) (
   input  logic [7:0]           bus,
   input  logic [4:0]           dev,
   output logic [NUM_SLOTS-1:0] hit
);
   logic [NUM_SLOTS-1:0] raw;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
      assign raw[i] = (bus == SLOT_BUS[8*i +: 8]) && (dev == SLOT_DEV[5*i +: 5]);
   end

   // Lowest slot index wins when entries alias.
   always_comb begin
      hit = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (raw[i]) begin
            hit    = '0;
            hit[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
   import cfgp_pkg::*;
#(
   parameter int                     ADDR_W    = 22,
   parameter int                     NUM_SLOTS = 4,
   parameter logic [NUM_SLOTS*8-1:0] SLOT_BUS  = 32'h0001_0000,
   parameter logic [NUM_SLOTS*5-1:0] SLOT_DEV  = {5'd13, 5'd0, 5'd14, 5'd13}
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [1:0]              cpu_size,
   input  logic [31:0]             cpu_wdata,
   output logic [31:0]             cpu_rdata,
   output logic [NUM_SLOTS-1:0]    cfg_stb,
   output logic                    cfg_we,
   output logic [5:0]              cfg_reg,
   output logic [3:0]              cfg_be,
   output logic [31:0]             cfg_wdata,
   input  logic [NUM_SLOTS*32-1:0] cfg_rdata,
   output logic                    err_size,
   output logic                    err_unsup
);
   localparam int LANES = 4;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_chk_slots
      $error("NUM_SLOTS must lie in 1..4");
   end
   if (ADDR_W < 22) begin : g_chk_aw
      $error("ADDR_W too narrow for the data window");
   end

   size_e                sz;
   logic                 hit_a, hit_d;
   logic [1:0]           lane;
   logic [31:0]          addr_q;
   logic [31:0]          latch_q;
   logic                 rd_pend;
   logic [NUM_SLOTS-1:0] stb_q;
   logic                 we_q;
   logic [3:0]           be_q;
   logic [5:0]           reg_q;
   cfg_addr_t            cur, nxt, src;
   logic [NUM_SLOTS-1:0] hit;
   logic [31:0]          sel_rd;
   logic [31:0]          capture;
   logic                 legal;
   logic [3:0]           be_n;
   logic [31:0]          merged;
   logic [31:0]          rd_val;
   logic                 acc_aw, data_wr, data_rd;

   assign sz = size_e'(cpu_size);

   cfgp_window_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (cpu_addr),
      .hit_addr (hit_a),
      .hit_data (hit_d),
      .lane     (lane)
   );

   assign acc_aw  = cpu_req && cpu_we && hit_a;
   assign data_wr = cpu_req && cpu_we && hit_d;
   assign data_rd = cpu_req && !cpu_we && hit_d;

   assign cur = split_addr(addr_q);
   assign nxt = split_addr(cpu_wdata);
   assign src = acc_aw ? nxt : cur;

   cfgp_slot_match #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_BUS  (SLOT_BUS),
      .SLOT_DEV  (SLOT_DEV)
   ) u_match (
      .bus (src.bus),
      .dev (src.dev),
      .hit (hit)
   );

   always_comb begin
      sel_rd = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (stb_q[i]) sel_rd = sel_rd | cfg_rdata[32*i +: 32];
      end
      capture = rd_pend ? ((|stb_q) ? sel_rd : 32'd0) : latch_q;
   end

   cfgp_lane_unit #(.LANES(LANES)) u_lane (
      .latch  (capture),
      .lane   (lane),
      .size   (sz),
      .wdata  (cpu_wdata),
      .legal  (legal),
      .be     (be_n),
      .merged (merged),
      .rd_val (rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         latch_q   <= '0;
         rd_pend   <= 1'b0;
         stb_q     <= '0;
         we_q      <= 1'b0;
         be_q      <= '0;
         reg_q     <= '0;
         err_size  <= 1'b0;
         err_unsup <= 1'b0;
      end else begin
         stb_q   <= '0;
         we_q    <= 1'b0;
         rd_pend <= 1'b0;
         latch_q <= capture;
         if (acc_aw) begin
            if (sz == SZ_WORD) begin
               addr_q <= cpu_wdata;
               if (nxt.en) begin
                  stb_q   <= hit;
                  rd_pend <= 1'b1;
                  be_q    <= 4'hF;
                  reg_q   <= nxt.reg_ix;
                  if (nxt.fn != 3'd0 || nxt.kind != 2'd0) err_unsup <= 1'b1;
               end
            end else begin
               err_size <= 1'b1;
            end
         end
         if (data_wr) begin
            if (!legal) begin
               err_size <= 1'b1;
            end else if (cur.en) begin
               latch_q <= merged;
               stb_q   <= hit;
               we_q    <= 1'b1;
               be_q    <= be_n;
               reg_q   <= cur.reg_ix;
               if (cur.fn != 3'd0 || cur.kind != 2'd0) err_unsup <= 1'b1;
            end
         end
         if (data_rd && !legal) err_size <= 1'b1;
      end
   end

   assign cfg_stb   = stb_q;
   assign cfg_we    = we_q;
   assign cfg_be    = be_q;
   assign cfg_reg   = reg_q;
   assign cfg_wdata = latch_q;

   always_comb begin
      if (hit_a)      cpu_rdata = addr_q;
      else if (hit_d) cpu_rdata = rd_val;
      else            cpu_rdata = '0;
   end

   // Assertions
   assert_onehot_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cfg_stb));

   assert_stb_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|cfg_stb) |-> addr_q[31]);

   assert_read_full_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cfg_stb) && !cfg_we) |-> (cfg_be == 4'hF));

   assert_illegal_keeps_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !legal && !rd_pend) |=> (cfg_wdata == $past(cfg_wdata)));

   assert_write_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && legal && addr_q[31] && (|hit)) |=> ((|cfg_stb) && cfg_we));

   assert_sticky_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_size |=> err_size);

   assert_sticky_unsup_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_unsup |=> err_unsup);

endmodule

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;
   localparam int AW = 22;
   localparam int NS = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cpu_req = 1'b0;
   logic           cpu_we = 1'b0;
   logic [AW-1:0]  cpu_addr = '0;
   logic [1:0]     cpu_size = 2'd0;
   logic [31:0]    cpu_wdata = '0;
   logic [31:0]    cpu_rdata;
   logic [NS-1:0]  cfg_stb;
   logic           cfg_we;
   logic [5:0]     cfg_reg;
   logic [3:0]     cfg_be;
   logic [31:0]    cfg_wdata;
   logic [NS*32-1:0] cfg_rdata;
   logic           err_size, err_unsup;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   // Target model: slot i answers {5A, C0+i, reg index, 3E}.
   for (genvar i = 0; i < NS; i++) begin : g_tgt
      assign cfg_rdata[32*i +: 32] = {8'h5A, 8'hC0 + 8'(i), 2'b00, cfg_reg, 8'h3E};
   end

   cfg_port_decoder uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cfg_stb(cfg_stb), .cfg_we(cfg_we),
      .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .err_size(err_size), .err_unsup(err_unsup)
   );

   // Read table: {address, size, expected} after loading slot0 reg 2.
   localparam logic [55:0] TBL [10] = '{
      {22'h200000, 2'd2, 32'h5AC0023E},
      {22'h200000, 2'd1, 32'h0000023E},
      {22'h200002, 2'd1, 32'h00005AC0},
      {22'h200000, 2'd0, 32'h0000003E},
      {22'h200001, 2'd0, 32'h00000002},
      {22'h200002, 2'd0, 32'h000000C0},
      {22'h200003, 2'd0, 32'h0000005A},
      {22'h000CFC, 2'd2, 32'h5AC0023E},
      {22'h000CFE, 2'd1, 32'h00005AC0},
      {22'h000CFF, 2'd0, 32'h0000005A}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Returns at the negedge after the capturing posedge: strobes visible.
   task automatic wr(input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_size = s; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [1:0] s, output logic [31:0] v);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_size = s;
      #1 v = cpu_rdata;
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R10 reset state
      rd(22'h000CF8, 2'd2, v);        check("R10 addr reset", v, 32'd0);
      rd(22'h200000, 2'd2, v);        check("R10 latch reset", v, 32'd0);
      check("R10 flags reset", {30'd0, err_size, err_unsup}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 no strobe", {28'd0, cfg_stb}, 32'd0);

      // R2 enabled address write starts read to slot0
      wr(22'h000000, 2'd2, 32'h8000_6808);
      check("R2 stb", {28'd0, cfg_stb}, 32'h1);
      check("R2 we/be/reg", {24'd0, cfg_we, cfg_be, cfg_reg[2:0]}, {24'd0, 1'b0, 4'hF, 3'd2});
      rd(22'h000CF8, 2'd2, v);        check("R1 mirror read", v, 32'h8000_6808);

      // R4 / R3 table of reads
      for (int i = 0; i < 10; i++) begin
         rd(TBL[i][55:34], TBL[i][33:32], v);
         check("R4 R3 lane read", v, TBL[i][31:0]);
      end

      // R1 non-word write to address port
      check("R5 err_size clear", {31'd0, err_size}, 32'd0);
      wr(22'h000CF8, 2'd1, 32'h0000_1234);
      rd(22'h000000, 2'd2, v);        check("R1 addr unchanged", v, 32'h8000_6808);
      check("R1 err_size set", {31'd0, err_size}, 32'd1);

      // R5 illegal sizes
      wr(22'h200001, 2'd2, 32'hFFFF_FFFF);
      check("R5 no strobe", {28'd0, cfg_stb}, 32'd0);
      rd(22'h200000, 2'd2, v);        check("R5 latch kept", v, 32'h5AC0023E);
      rd(22'h200001, 2'd1, v);        check("R5 illegal read zero", v, 32'd0);
      rd(22'h200002, 2'd2, v);        check("R5 word at lane2 zero", v, 32'd0);

      // R6 merges and write cycles
      wr(22'h200001, 2'd0, 32'h0000_0077);
      check("R6 byte stb", {28'd0, cfg_stb, 3'd0, cfg_we}, {28'd0, 4'h1, 3'd0, 1'b1});
      check("R6 byte be", {28'd0, cfg_be}, 32'h2);
      check("R6 byte wdata", cfg_wdata, 32'h5AC0773E);
      wr(22'h000CFE, 2'd1, 32'h0000_1234);
      check("R6 half be", {28'd0, cfg_be}, 32'hC);
      check("R6 half wdata", cfg_wdata, 32'h1234773E);
      wr(22'h200000, 2'd2, 32'hDEAD_BEEF);
      check("R6 word be", {28'd0, cfg_be}, 32'hF);
      check("R6 word wdata", cfg_wdata, 32'hDEADBEEF);
      check("R6 word reg", {26'd0, cfg_reg}, 32'd2);
      rd(22'h200000, 2'd2, v);        check("R6 readback", v, 32'hDEADBEEF);

      // R3 unmatched target
      wr(22'h000000, 2'd2, 32'h8005_0010);
      check("R3 unmatched no stb", {28'd0, cfg_stb}, 32'd0);
      rd(22'h200000, 2'd2, v);        check("R3 unmatched zero", v, 32'd0);

      // slot2: bus1 dev0 reg1
      wr(22'h000000, 2'd2, 32'h8001_0004);
      check("R2 slot2 stb", {28'd0, cfg_stb}, 32'h4);
      rd(22'h200000, 2'd2, v);        check("R3 slot2 data", v, 32'h5AC2013E);

      // R9 duplicate slot 3 aliases slot 0; slot1 dev14
      wr(22'h000000, 2'd2, 32'h8000_6800);
      check("R9 lowest slot wins", {28'd0, cfg_stb}, 32'h1);
      wr(22'h000000, 2'd2, 32'h8000_700C);
      check("R9 slot1", {28'd0, cfg_stb}, 32'h2);
      rd(22'h200000, 2'd2, v);        check("R3 slot1 data", v, 32'h5AC1033E);

      // R7 enable clear
      wr(22'h000000, 2'd2, 32'h0000_6808);
      check("R7 addr no stb", {28'd0, cfg_stb}, 32'd0);
      rd(22'h000000, 2'd2, v);        check("R7 addr stored", v, 32'h0000_6808);
      wr(22'h200000, 2'd0, 32'h0000_0011);
      check("R7 data no stb", {28'd0, cfg_stb}, 32'd0);
      rd(22'h200000, 2'd2, v);        check("R7 latch kept", v, 32'h5AC1033E);

      // R8 nonzero function and type
      check("R8 unsup clear", {31'd0, err_unsup}, 32'd0);
      wr(22'h000000, 2'd2, 32'h8000_6A09);
      check("R8 still slot0", {28'd0, cfg_stb}, 32'h1);
      check("R8 reg", {26'd0, cfg_reg}, 32'd2);
      check("R8 unsup set", {31'd0, err_unsup}, 32'd1);
      rd(22'h200000, 2'd2, v);        check("R8 data", v, 32'h5AC0023E);

      // R10 stickiness, then reset
      wr(22'h000000, 2'd2, 32'h8000_6808);
      check("R10 flags sticky", {30'd0, err_size, err_unsup}, 32'h3);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 flags after reset", {30'd0, err_size, err_unsup}, 32'd0);
      rd(22'h000000, 2'd2, v);        check("R10 addr after reset", v, 32'd0);
      rd(22'h200000, 2'd2, v);        check("R10 latch after reset", v, 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule